// File: doc/BRIEF.md
# PCI Host Bridge Address Window Decoder

This block sits between a processor bus and a PCI bus and decides, for every address it is shown, where that address belongs. On the processor side, the top 256 MiB of the 32-bit space (from 0xF0000000) is split into 32 chunks of 8 MiB each. Software turns forwarding on for each chunk with its own bit. A two-bit mode field in a control word turns forwarding on or off for all chunks at once. When an address falls in an enabled chunk, the block signals a hit, reports the chunk number and passes the address to the PCI side unchanged.

On the PCI side, the block sorts bus-master addresses into one of four classes: host memory, PCI memory, processor-local space, or a decode miss. Both decoders are combinational. They work from two registers that software writes and reads back through a simple word port. The block moves no data. It only produces hit and target indications for the datapaths around it.

Top module: `pcib_win_top`

## Requirements
- R1: After synchronous active-low reset, the control word and the enable word both read as zero, and no processor address produces a hit.
- R2: A write at offset 0x038 stores all 32 bits of the control word, and a read at that offset returns them unchanged.
- R3: A write at offset 0x060 stores the written value ANDed with 0x7FFFFFFE into the enable word, so bits 0 and 31 always read as zero. A read at that offset returns the stored value.
- R4: Forwarding is active only while control bits [8:7] equal 2'b01. The values 2'b00, 2'b10 and 2'b11 suppress every hit.
- R5: Address A hits when forwarding is active, A[31:28] is 4'hF and enable bit A[27:23] is set. On a hit, cpu_win equals A[27:23] and pci_addr equals A. With no hit, cpu_hit, cpu_win and pci_addr are all zero.
- R6: Chunk 0 (0xF0000000–0xF07FFFFF) and chunk 31 (0xFF800000–0xFFFFFFFF) never hit, whatever is written. Addresses below 0xF0000000 never hit.
- R7: A bus-master address below 0xF0800000 raises bm_host only.
- R8: A bus-master address from 0xF0800000 through 0xFF7FFFFF raises bm_pci only.
- R9: A bus-master address from 0xFFF00000 through 0xFFFFEFFF raises bm_local only.
- R10: Any other bus-master address (0xFF800000–0xFFEFFFFF, or 0xFFFFF000–0xFFFFFFFF) raises bm_miss only. Exactly one of {bm_miss, bm_local, bm_pci, bm_host} is high at all times.
- R11: A register write changes decoding only from the cycle after the clock edge that captures it. A write to any offset other than 0x038 or 0x060 changes neither register, and a read of such an offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe, captured at the rising edge |
| reg_addr | input | 12 | Register byte offset, used for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| cpu_addr | input | 32 | Processor-side address to test against the windows |
| cpu_hit | output | 1 | Address lies in an enabled window |
| cpu_win | output | 5 | Number of the window that was hit |
| pci_addr | output | 32 | Forwarded PCI address (zero without a hit) |
| bm_addr | input | 32 | PCI bus-master address to classify |
| bm_host | output | 1 | Target is host memory |
| bm_pci | output | 1 | Target is PCI memory |
| bm_local | output | 1 | Target is processor-local space |
| bm_miss | output | 1 | Address matches no target range |

## Verification
The properties assume that reg_addr, reg_wdata and reg_wr_en are settled and known at every rising edge after reset. They also assume that cpu_addr and bm_addr are never X, because the one-hot and hit checks assume a defined decode. The stimulus changes every input only on the falling edge and releases reset before it issues the first register access. It also sweeps the addresses through the exact first and last bytes of each range, so that the range checks meet their boundaries with defined inputs.

// File: rtl/pcib_win_pkg.sv
// Package: shared constants and types for the address window decoder.
// Assumes a 32-bit address space and a word-wide register port.
package pcib_win_pkg;

    // Classification result of the bus-master decode path.
    typedef enum logic [1:0] {
        TGT_HOST  = 2'd0,
        TGT_PCI   = 2'd1,
        TGT_LOCAL = 2'd2,
        TGT_MISS  = 2'd3
    } bm_tgt_e;

    localparam int unsigned OFS_W        = 12;
    localparam logic [OFS_W-1:0] CTRL_OFS = 12'h038;
    localparam logic [OFS_W-1:0] EN_OFS   = 12'h060;

endpackage

// File: rtl/pcib_win_regs.sv
// Module: control word and per-window enable word, with write and readback.
// The enable word drops its first and last bits on every write. Reads are
// combinational. Unknown offsets read zero and ignore writes.
module pcib_win_regs #(
    parameter int unsigned DW     = 32,
    parameter int unsigned NCHUNK = 32,
    parameter int unsigned OFS_W  = 12,
    parameter logic [OFS_W-1:0] CTRL_OFS = 12'h038,
    parameter logic [OFS_W-1:0] EN_OFS   = 12'h060
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     ctrl_q,
    output logic [NCHUNK-1:0] en_q
);
    // Bits that may ever be set: every window except the two end ones.
    localparam logic [NCHUNK-1:0] EN_KEEP =
        ~(NCHUNK'(1) | (NCHUNK'(1) << (NCHUNK - 1)));

    // Capture writes to the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && addr == CTRL_OFS)
            ctrl_q <= wdata;
    end

    // Capture writes to the enable word with the end windows masked off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en && addr == EN_OFS)
            en_q <= wdata[NCHUNK-1:0] & EN_KEEP;
    end

    // Readback multiplexer.
    always_comb begin
        unique case (addr)
            CTRL_OFS: rdata = ctrl_q;
            EN_OFS:   rdata = DW'(en_q);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/pcib_win_outbound.sv
// Module: processor-side window match. One comparator per chunk is built by
// generate. Assumes that the chunks tile one aligned region whose top bits
// equal REGION_TAG. The hit vector is one-hot by construction, because
// each chunk matches a different index.
module pcib_win_outbound #(
    parameter int unsigned AW        = 32,
    parameter int unsigned DW        = 32,
    parameter int unsigned NCHUNK    = 32,
    parameter int unsigned CHUNK_LG  = 23,
    parameter int unsigned MODE_LSB  = 7,
    parameter logic [1:0]  MODE_ON   = 2'b01,
    parameter int unsigned IDX_W     = $clog2(NCHUNK),
    parameter logic [AW-CHUNK_LG-IDX_W-1:0] REGION_TAG = '1
) (
    input  logic [AW-1:0]     cpu_addr,
    input  logic [DW-1:0]     ctrl,
    input  logic [NCHUNK-1:0] en,
    output logic              hit,
    output logic [IDX_W-1:0]  win,
    output logic [AW-1:0]     pci_addr
);
    localparam int unsigned REGION_LG = CHUNK_LG + IDX_W;

    logic              fwd_on;
    logic              in_region;
    logic [IDX_W-1:0]  chunk_idx;
    logic [NCHUNK-1:0] hit_vec;

    // Global gate from the mode field.
    assign fwd_on    = (ctrl[MODE_LSB +: 2] == MODE_ON);
    assign in_region = (cpu_addr[AW-1:REGION_LG] == REGION_TAG);
    assign chunk_idx = cpu_addr[REGION_LG-1:CHUNK_LG];

    // One match term per chunk.
    for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
        assign hit_vec[i] = fwd_on && in_region && en[i] &&
                            (chunk_idx == IDX_W'(i));
    end

    // Encode the matching chunk number.
    always_comb begin
        win = '0;
        for (int i = 0; i < NCHUNK; i++)
            if (hit_vec[i]) win = win | IDX_W'(i);
    end

    assign hit      = |hit_vec;
    assign pci_addr = hit ? cpu_addr : '0;
endmodule

// File: rtl/pcib_win_inbound.sv
// Module: bus-master address classifier. The ranges are checked in a fixed
// priority: host memory, then PCI memory, then processor-local space.
// Anything left over is a miss. Assumes that the ranges are ordered and
// do not overlap.
module pcib_win_inbound
    import pcib_win_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned NCHUNK   = 32,
    parameter int unsigned CHUNK_LG = 23,
    parameter logic [AW-1:0] REGION_BASE = 32'hF000_0000,
    parameter logic [AW-1:0] LOCAL_LO    = 32'hFFF0_0000,
    parameter logic [AW-1:0] LOCAL_HI    = 32'hFFFF_EFFF
) (
    input  logic [AW-1:0] bm_addr,
    output bm_tgt_e       tgt
);
    localparam logic [AW-1:0] CHUNK_SZ = AW'(1) << CHUNK_LG;
    localparam logic [AW-1:0] PCI_LO   = REGION_BASE + CHUNK_SZ;
    localparam logic [AW-1:0] PCI_END  = REGION_BASE + CHUNK_SZ * AW'(NCHUNK - 1);

    // Range compare in priority order.
    always_comb begin
        if (bm_addr < PCI_LO)
            tgt = TGT_HOST;
        else if (bm_addr < PCI_END)
            tgt = TGT_PCI;
        else if (bm_addr >= LOCAL_LO && bm_addr <= LOCAL_HI)
            tgt = TGT_LOCAL;
        else
            tgt = TGT_MISS;
    end
endmodule

// File: rtl/pcib_win_top.sv
// Module: top of the address window decoder. It holds the register file
// and both decode paths. The register port is single-cycle: writes land
// at the rising edge and reads are combinational.
module pcib_win_top
    import pcib_win_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned DW       = 32,
    parameter int unsigned NCHUNK   = 32,
    parameter int unsigned CHUNK_LG = 23,
    parameter int unsigned IDX_W    = $clog2(NCHUNK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [OFS_W-1:0] reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic [AW-1:0]    cpu_addr,
    output logic             cpu_hit,
    output logic [IDX_W-1:0] cpu_win,
    output logic [AW-1:0]    pci_addr,
    input  logic [AW-1:0]    bm_addr,
    output logic             bm_host,
    output logic             bm_pci,
    output logic             bm_local,
    output logic             bm_miss
);
    logic [DW-1:0]     ctrl_q;
    logic [NCHUNK-1:0] en_q;
    bm_tgt_e           bm_tgt;

    pcib_win_regs #(
        .DW(DW), .NCHUNK(NCHUNK), .OFS_W(OFS_W),
        .CTRL_OFS(CTRL_OFS), .EN_OFS(EN_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ctrl_q(ctrl_q), .en_q(en_q)
    );

    pcib_win_outbound #(
        .AW(AW), .DW(DW), .NCHUNK(NCHUNK), .CHUNK_LG(CHUNK_LG),
        .MODE_LSB(7), .MODE_ON(2'b01), .IDX_W(IDX_W)
    ) u_out (
        .cpu_addr(cpu_addr), .ctrl(ctrl_q), .en(en_q),
        .hit(cpu_hit), .win(cpu_win), .pci_addr(pci_addr)
    );

    pcib_win_inbound #(
        .AW(AW), .NCHUNK(NCHUNK), .CHUNK_LG(CHUNK_LG)
    ) u_in (
        .bm_addr(bm_addr), .tgt(bm_tgt)
    );

    // Expand the class code into one strobe per target.
    assign bm_host  = (bm_tgt == TGT_HOST);
    assign bm_pci   = (bm_tgt == TGT_PCI);
    assign bm_local = (bm_tgt == TGT_LOCAL);
    assign bm_miss  = (bm_tgt == TGT_MISS);
endmodule

// File: rtl/pcib_win_checker.sv
// Module: assertion checker bound to the decoder top. Observes the ports and
// the two registers; drives nothing.
module pcib_win_checker #(
    parameter int unsigned AW     = 32,
    parameter int unsigned DW     = 32,
    parameter int unsigned NCHUNK = 32,
    parameter int unsigned IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [11:0]       reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic [AW-1:0]     cpu_addr,
    input logic              cpu_hit,
    input logic [IDX_W-1:0]  cpu_win,
    input logic [AW-1:0]     pci_addr,
    input logic [AW-1:0]     bm_addr,
    input logic              bm_host,
    input logic              bm_pci,
    input logic              bm_local,
    input logic              bm_miss,
    input logic [DW-1:0]     ctrl_q,
    input logic [NCHUNK-1:0] en_q
);
    assert_bm_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({bm_miss, bm_local, bm_pci, bm_host}));

    assert_host_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bm_host |-> bm_addr < 32'hF080_0000);

    assert_hit_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> ctrl_q[8:7] == 2'b01);

    assert_hit_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> (pci_addr == cpu_addr) && en_q[cpu_win]);

    assert_end_chunks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> (cpu_win != '0) && (cpu_win != IDX_W'(NCHUNK - 1)));

    assert_en_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 12'h060) |=>
            (en_q[0] == 1'b0) && (en_q[NCHUNK-1] == 1'b0) &&
            (en_q[NCHUNK-2:1] == $past(reg_wdata[NCHUNK-2:1])));

    assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_addr == 12'h038) |=> $stable(ctrl_q));
endmodule

bind pcib_win_top pcib_win_checker #(
    .AW(AW), .DW(DW), .NCHUNK(NCHUNK), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cpu_addr(cpu_addr), .cpu_hit(cpu_hit),
    .cpu_win(cpu_win), .pci_addr(pci_addr), .bm_addr(bm_addr),
    .bm_host(bm_host), .bm_pci(bm_pci), .bm_local(bm_local),
    .bm_miss(bm_miss), .ctrl_q(ctrl_q), .en_q(en_q)
);

// File: tb/tb_pcib_win_top.sv
`timescale 1ns/1ps
module tb_pcib_win_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] cpu_addr = '0;
    logic        cpu_hit;
    logic [4:0]  cpu_win;
    logic [31:0] pci_addr;
    logic [31:0] bm_addr = '0;
    logic        bm_host, bm_pci, bm_local, bm_miss;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Model state: derived from the requirements only.
    logic [31:0] m_ctrl = '0;
    logic [31:0] m_en   = '0;

    typedef struct {
        string       req;
        int          sel;    // 0 rdata, 1 hit, 2 win, 3 pci_addr, 4 bm class
        logic [31:0] exp;
    } item_t;
    item_t sb[$];
    event mon_ev;

    always #2.5 clk = ~clk;

    pcib_win_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
        .cpu_hit(cpu_hit), .cpu_win(cpu_win), .pci_addr(pci_addr),
        .bm_addr(bm_addr), .bm_host(bm_host), .bm_pci(bm_pci),
        .bm_local(bm_local), .bm_miss(bm_miss)
    );

    // Monitor: pop expected items and compare against the settled outputs.
    initial begin
        forever begin
            @(mon_ev);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.sel)
                    0: act = reg_rdata;
                    1: act = {31'b0, cpu_hit};
                    2: act = {27'b0, cpu_win};
                    3: act = pci_addr;
                    default: act = {28'b0, bm_miss, bm_local, bm_pci, bm_host};
                endcase
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic push(input string req, input int sel, input logic [31:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic settle();
        #1; ->mon_ev; #0.5;
    endtask

    // Expected window result from the R4/R5/R6 rules.
    function automatic logic [37:0] exp_cpu(input logic [31:0] a);
        logic hit;
        logic [4:0] k;
        k = a[27:23];
        hit = (m_ctrl[8:7] == 2'b01) && (a[31:28] == 4'hF) && m_en[k];
        return hit ? {1'b1, k, a} : 38'd0;
    endfunction

    // Expected bus-master class {miss,local,pci,host} from R7..R10.
    function automatic logic [31:0] exp_bm(input logic [31:0] a);
        if (a < 32'hF080_0000) return 32'h1;
        if (a <= 32'hFF7F_FFFF) return 32'h2;
        if (a >= 32'hFFF0_0000 && a <= 32'hFFFF_EFFF) return 32'h4;
        return 32'h8;
    endfunction

    task automatic check_cpu(input string req, input logic [31:0] a);
        logic [37:0] e;
        @(negedge clk);
        cpu_addr = a;
        e = exp_cpu(a);
        push(req, 1, {31'b0, e[37]});
        push(req, 2, {27'b0, e[36:32]});
        push(req, 3, e[31:0]);
        settle();
    endtask

    task automatic check_bm(input string req, input logic [31:0] a);
        @(negedge clk);
        bm_addr = a;
        push(req, 4, exp_bm(a));
        settle();
    endtask

    task automatic check_rd(input string req, input logic [11:0] ofs, input logic [31:0] e);
        @(negedge clk);
        reg_addr = ofs;
        push(req, 0, e);
        settle();
    endtask

    task automatic reg_write(input logic [11:0] ofs, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = ofs; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (ofs == 12'h038) m_ctrl = d;
        if (ofs == 12'h060) m_en = d & 32'h7FFF_FFFE;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_rd("R1", 12'h038, 32'h0);
        check_rd("R1", 12'h060, 32'h0);
        check_cpu("R1", 32'hF080_0000);

        // R2: control readback, forwarding mode on
        reg_write(12'h038, 32'hA5A5_00C0 | 32'h80);
        m_ctrl = 32'hA5A5_0080 | 32'h40;
        check_rd("R2", 12'h038, 32'hA5A5_00C0);

        // R3: enable masking
        reg_write(12'h060, 32'hFFFF_FFFF);
        check_rd("R3", 12'h060, 32'h7FFF_FFFE);

        // R5 / R6: sweep every chunk, all enabled
        for (int i = 0; i < 32; i++)
            check_cpu((i == 0 || i == 31) ? "R6" : "R5",
                      32'hF000_0000 + (i << 23) + 32'h0001_2345);
        check_cpu("R6", 32'h1234_5678);
        check_cpu("R6", 32'hEFFF_FFFF);
        check_cpu("R5", 32'hFF7F_FFFF);

        // R5: a single window
        reg_write(12'h060, 32'h0000_0004);
        check_cpu("R5", 32'hF100_0000);
        check_cpu("R5", 32'hF17F_FFFF);
        check_cpu("R5", 32'hF180_0000);

        // R4: other mode values suppress hits
        reg_write(12'h038, 32'h0000_0000);
        check_cpu("R4", 32'hF100_0010);
        reg_write(12'h038, 32'h0000_0100);
        check_cpu("R4", 32'hF100_0010);
        reg_write(12'h038, 32'h0000_0180);
        check_cpu("R4", 32'hF100_0010);
        reg_write(12'h038, 32'h0000_0080);
        check_cpu("R4", 32'hF100_0010);

        // R11: write visible only after its capturing edge
        cpu_addr = 32'hF100_0020;
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 12'h060; reg_wdata = 32'h0;
        push("R11", 1, 32'h1);
        settle();
        @(negedge clk);
        reg_wr_en = 1'b0;
        m_en = '0;
        push("R11", 1, 32'h0);
        settle();

        // R11: unmapped offset ignored
        reg_write(12'h064, 32'hFFFF_FFFF);
        check_rd("R11", 12'h064, 32'h0);
        check_rd("R11", 12'h038, 32'h0000_0080);
        check_rd("R11", 12'h060, 32'h0);

        // R7..R10: bus-master boundaries
        check_bm("R7", 32'h0000_0000);
        check_bm("R7", 32'hF07F_FFFF);
        check_bm("R8", 32'hF080_0000);
        check_bm("R8", 32'hFF7F_FFFF);
        check_bm("R10", 32'hFF80_0000);
        check_bm("R10", 32'hFFEF_FFFF);
        check_bm("R9", 32'hFFF0_0000);
        check_bm("R9", 32'hFFFF_EFFF);
        check_bm("R10", 32'hFFFF_F000);
        check_bm("R10", 32'hFFFF_FFFF);

        // R1: reset clears state again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_ctrl = '0; m_en = '0;
        check_rd("R1", 12'h038, 32'h0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule